// File: doc/BRIEF.md
# Flash Suspend Command Gate

This block sits behind the opcode decoder of a serial NOR flash and decides, for every decoded 8-bit command, whether the rest of the device may act on it. It follows the suspend status reported by the embedded program/erase controller, so it always knows whether the device is idle, erase-suspended, program-suspended, or program-suspended inside an erase suspend. The states are `ST_IDLE`, `ST_ERS_SUSP`, `ST_PGM_SUSP` and `ST_NEST_SUSP`. In idle every command passes. While suspended, only reads, status reads, the software reset and a few commands needed to program during an erase suspend get through. Any other command is turned away and leaves no trace.

The controller reports its state changes through three one-cycle event strobes: erase suspended, program suspended, and resumed. The named transitions are:
- `IDLE->ERS` on erase suspend.
- `IDLE->PGM` on program suspend.
- `ERS->NEST` on program suspend.
- `NEST->ERS`, `ERS->IDLE` and `PGM->IDLE` on resume.
- `ANY->IDLE` on an admitted software reset, or on `rst_n`.

The gate also enforces an ordering rule. While the device is suspended, a register write is admitted only if the previously admitted command was the bank-register access command.

The verdict appears one clock after the opcode strobe, as a single-cycle pulse on either accept or reject. A command presented in the same cycle as an event is judged in the state held before that event.

Top module: `flash_suspend_gate`

## Requirements
- R1: After reset the gate is in `ST_IDLE`, `op_accept_o` and `op_reject_o` are low, `nested_susp_o` is low and the bank-access memory is clear.
- R2: Every cycle with `op_valid_i` high yields exactly one pulse on `op_accept_o` or `op_reject_o` in the following cycle, and neither output pulses otherwise. In `ST_IDLE` every opcode is accepted.
- R3: An erase-suspend event moves `ST_IDLE` to `ST_ERS_SUSP`. A program-suspend event moves `ST_IDLE` to `ST_PGM_SUSP` and moves `ST_ERS_SUSP` to `ST_NEST_SUSP`. `nested_susp_o` is high exactly while the state is `ST_NEST_SUSP`.
- R4: A resume event moves `ST_NEST_SUSP` to `ST_ERS_SUSP`, and moves `ST_ERS_SUSP` or `ST_PGM_SUSP` to `ST_IDLE`. An event with no transition listed for the current state is ignored.
- R5: In all three suspended states these opcodes are accepted:
  - the array reads 0x03, 0x13, 0x3B, 0x3C, 0x6B, 0x6C, 0xBB, 0xBC, 0xBD, 0xBE, 0xEB, 0xEC, 0xED and 0xEE;
  - the status reads 0x05 and 0x07;
  - the bank-access command 0xB9.
- R6: In `ST_ERS_SUSP` the opcodes 0x85, 0x02, 0x12, 0x32, 0x38, 0x34, 0xE2 and 0x06 are also accepted. They are rejected in `ST_PGM_SUSP` and `ST_NEST_SUSP`.
- R7: The software reset 0xF0 is accepted in every state. Its acceptance returns the gate to `ST_IDLE` and clears the bank-access memory.
- R8: In a suspended state, the register write 0x01 is accepted only when the previous accepted command was 0xB9. Any other accepted command in between clears that permission.
- R9: A rejected command changes neither the state nor the bank-access memory.
- R10: In a suspended state, any opcode not admitted by R5 to R8 is rejected.
- R11: Same-cycle priority is as follows. An accepted 0xF0 overrides every event. In `ST_ERS_SUSP`, resume overrides program suspend. In `ST_IDLE`, erase suspend overrides program suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | One-cycle strobe: a decoded opcode is present |
| opcode_i | input | 8 | Decoded command opcode |
| erase_susp_evt_i | input | 1 | Controller reports that an erase is now suspended |
| prog_susp_evt_i | input | 1 | Controller reports that a program is now suspended |
| resume_evt_i | input | 1 | Controller reports that the innermost suspended operation has resumed |
| op_accept_o | output | 1 | Command admitted (one cycle after the strobe) |
| op_reject_o | output | 1 | Command refused (one cycle after the strobe) |
| nested_susp_o | output | 1 | Program suspend nested inside an erase suspend is active |

## Verification
Two situations are hard to reach from the ports. The first is the nested state, which needs an erase-suspend event followed by a program-suspend event with no resume or software reset in between. The second is the bank-write rule, which needs 0xB9 and 0x01 to arrive back to back with only rejected commands between them, while the gate is suspended.

Directed sequences walk both situations, including a rejected opcode placed between 0xB9 and 0x01, and same-cycle collisions of the software reset and resume with suspend events. The random phase then draws opcodes mostly from the listed sets, with occasional arbitrary bytes and sparse events. This makes long nested stays and bank sequences frequent enough to recur many times.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ERS_SUSP  = 2'd1,
        ST_PGM_SUSP  = 2'd2,
        ST_NEST_SUSP = 2'd3
    } gate_state_e;

    localparam int OPW = 8;

    // Array read opcodes admitted in any suspended state
    localparam int N_READ_OPS = 14;
    localparam logic [N_READ_OPS*OPW-1:0] READ_OP_SET = {
        8'h03, 8'h13, 8'h3B, 8'h3C, 8'h6B, 8'h6C, 8'hBB,
        8'hBC, 8'hBD, 8'hBE, 8'hEB, 8'hEC, 8'hED, 8'hEE
    };

    // Status reads admitted in any suspended state
    localparam int N_STAT_OPS = 2;
    localparam logic [N_STAT_OPS*OPW-1:0] STAT_OP_SET = {8'h05, 8'h07};

    // Extra opcodes admitted only while an erase is suspended
    localparam int N_ERS_OPS = 8;
    localparam logic [N_ERS_OPS*OPW-1:0] ERS_OP_SET = {
        8'h85, 8'h02, 8'h12, 8'h32, 8'h38, 8'h34, 8'hE2, 8'h06
    };

    localparam logic [OPW-1:0] OP_SOFT_RST = 8'hF0;
    localparam logic [OPW-1:0] OP_BANK_ACC = 8'hB9;
    localparam logic [OPW-1:0] OP_REG_WR   = 8'h01;

    typedef struct packed {
        logic read;
        logic status;
        logic ers_extra;
        logic soft_rst;
        logic bank_acc;
        logic reg_wr;
    } op_class_t;

endpackage

// File: rtl/fsg_op_match.sv
module fsg_op_match #(
    parameter int                   W   = 8,
    parameter int                   N   = 2,
    parameter logic [N*W-1:0]       SET = '0
) (
    input  logic [W-1:0] op_i,
    output logic         hit_o
);
    logic [N-1:0] hits;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hits[g] = (op_i == SET[g*W +: W]);
    end

    assign hit_o = |hits;
endmodule

// File: rtl/fsg_op_classify.sv
module fsg_op_classify
    import fsg_pkg::*;
(
    input  logic [OPW-1:0] op_i,
    output op_class_t      cls_o
);
    logic read_hit, stat_hit, ers_hit;

    fsg_op_match #(.W(OPW), .N(N_READ_OPS), .SET(READ_OP_SET)) u_read (
        .op_i (op_i),
        .hit_o(read_hit)
    );

    fsg_op_match #(.W(OPW), .N(N_STAT_OPS), .SET(STAT_OP_SET)) u_stat (
        .op_i (op_i),
        .hit_o(stat_hit)
    );

    fsg_op_match #(.W(OPW), .N(N_ERS_OPS), .SET(ERS_OP_SET)) u_ers (
        .op_i (op_i),
        .hit_o(ers_hit)
    );

    always_comb begin
        cls_o           = '0;
        cls_o.read      = read_hit;
        cls_o.status    = stat_hit;
        cls_o.ers_extra = ers_hit;
        cls_o.soft_rst  = (op_i == OP_SOFT_RST);
        cls_o.bank_acc  = (op_i == OP_BANK_ACC);
        cls_o.reg_wr    = (op_i == OP_REG_WR);
    end
endmodule

// File: rtl/fsg_state_fsm.sv
module fsg_state_fsm
    import fsg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst_i,
    input  logic        erase_susp_evt_i,
    input  logic        prog_susp_evt_i,
    input  logic        resume_evt_i,
    output gate_state_e state_o
);
    gate_state_e state_q, state_d;

    // next-state: soft reset dominates, then resume, then suspend events
    always_comb begin
        state_d = state_q;
        if (soft_rst_i) begin
            state_d = ST_IDLE;                                  // ANY->IDLE
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (erase_susp_evt_i)     state_d = ST_ERS_SUSP;  // IDLE->ERS
                    else if (prog_susp_evt_i) state_d = ST_PGM_SUSP;  // IDLE->PGM
                end
                ST_ERS_SUSP: begin
                    if (resume_evt_i)         state_d = ST_IDLE;      // ERS->IDLE
                    else if (prog_susp_evt_i) state_d = ST_NEST_SUSP; // ERS->NEST
                end
                ST_PGM_SUSP: begin
                    if (resume_evt_i)         state_d = ST_IDLE;      // PGM->IDLE
                end
                ST_NEST_SUSP: begin
                    if (resume_evt_i)         state_d = ST_ERS_SUSP;  // NEST->ERS
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/fsg_bank_track.sv
module fsg_bank_track (
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic is_bank_acc_i,
    input  logic soft_rst_i,
    output logic bank_ok_o
);
    logic bank_q;

    // remembers whether the last admitted command was the bank access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          bank_q <= 1'b0;
        else if (soft_rst_i) bank_q <= 1'b0;
        else if (take_i)     bank_q <= is_bank_acc_i;
    end

    assign bank_ok_o = bank_q;
endmodule

// File: rtl/flash_suspend_gate.sv
module flash_suspend_gate
    import fsg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid_i,
    input  logic [OPW-1:0] opcode_i,
    input  logic           erase_susp_evt_i,
    input  logic           prog_susp_evt_i,
    input  logic           resume_evt_i,
    output logic           op_accept_o,
    output logic           op_reject_o,
    output logic           nested_susp_o
);
    op_class_t   cls;
    gate_state_e state_q;
    logic        bank_ok;
    logic        susp_common, admit, take, soft_rst_take;
    logic        acc_q, rej_q;

    fsg_op_classify u_cls (
        .op_i (opcode_i),
        .cls_o(cls)
    );

    assign susp_common = cls.read | cls.status | cls.soft_rst | cls.bank_acc
                       | (cls.reg_wr & bank_ok);

    // admission decision, taken in the state held before any same-cycle event
    always_comb begin
        admit = 1'b0;
        unique case (state_q)
            ST_IDLE:      admit = 1'b1;
            ST_ERS_SUSP:  admit = susp_common | cls.ers_extra;
            ST_PGM_SUSP:  admit = susp_common;
            ST_NEST_SUSP: admit = susp_common;
            default:      admit = 1'b0;
        endcase
    end

    assign take          = op_valid_i & admit;
    assign soft_rst_take = take & cls.soft_rst;

    fsg_state_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .soft_rst_i      (soft_rst_take),
        .erase_susp_evt_i(erase_susp_evt_i),
        .prog_susp_evt_i (prog_susp_evt_i),
        .resume_evt_i    (resume_evt_i),
        .state_o         (state_q)
    );

    fsg_bank_track u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_i       (take),
        .is_bank_acc_i(cls.bank_acc),
        .soft_rst_i   (soft_rst_take),
        .bank_ok_o    (bank_ok)
    );

    // registered verdict outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= 1'b0;
            rej_q <= 1'b0;
        end else begin
            acc_q <= take;
            rej_q <= op_valid_i & ~admit;
        end
    end

    assign op_accept_o   = acc_q;
    assign op_reject_o   = rej_q;
    assign nested_susp_o = (state_q == ST_NEST_SUSP);
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker
    import fsg_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           op_valid_i,
    input logic [OPW-1:0] opcode_i,
    input logic           resume_evt_i,
    input logic           op_accept_o,
    input logic           op_reject_o,
    input logic           nested_susp_o,
    input gate_state_e    state_q,
    input logic           bank_ok
);
    assert_verdict_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_accept_o, op_reject_o}));

    assert_verdict_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i |=> (op_accept_o ^ op_reject_o));

    assert_no_spurious_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> !(op_accept_o || op_reject_o));

    assert_idle_accepts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && state_q == ST_IDLE) |=> op_accept_o);

    assert_nested_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nested_susp_o) |-> $past(state_q == ST_ERS_SUSP));

    assert_nested_resume_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NEST_SUSP && resume_evt_i
         && !(op_valid_i && opcode_i == OP_SOFT_RST)) |=> state_q == ST_ERS_SUSP);

    assert_pgm_blocks_program_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && opcode_i == 8'h02
         && (state_q == ST_PGM_SUSP || state_q == ST_NEST_SUSP)) |=> op_reject_o);

    assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && opcode_i == OP_SOFT_RST) |=> (op_accept_o && state_q == ST_IDLE && !bank_ok));

    assert_regwr_needs_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && opcode_i == OP_REG_WR && state_q != ST_IDLE && !bank_ok) |=> op_reject_o);

    assert_reject_keeps_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && state_q != ST_IDLE && bank_ok && opcode_i == 8'h55) |=> bank_ok);
endmodule

bind flash_suspend_gate fsg_checker u_fsg_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid_i   (op_valid_i),
    .opcode_i     (opcode_i),
    .resume_evt_i (resume_evt_i),
    .op_accept_o  (op_accept_o),
    .op_reject_o  (op_reject_o),
    .nested_susp_o(nested_susp_o),
    .state_q      (state_q),
    .bank_ok      (bank_ok)
);

// File: tb/flash_suspend_gate_bench.sv
`timescale 1ns/1ps
module flash_suspend_gate_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid_i = 1'b0;
    logic [7:0] opcode_i = 8'h00;
    logic       erase_susp_evt_i = 1'b0;
    logic       prog_susp_evt_i = 1'b0;
    logic       resume_evt_i = 1'b0;
    logic       op_accept_o, op_reject_o, nested_susp_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    int  m_st = 0;      // 0 idle, 1 erase-susp, 2 prog-susp, 3 nested
    bit  m_bank = 1'b0;

    always #5 clk = ~clk;

    flash_suspend_gate u_flash_suspend_gate (
        .clk             (clk),
        .rst_n           (rst_n),
        .op_valid_i      (op_valid_i),
        .opcode_i        (opcode_i),
        .erase_susp_evt_i(erase_susp_evt_i),
        .prog_susp_evt_i (prog_susp_evt_i),
        .resume_evt_i    (resume_evt_i),
        .op_accept_o     (op_accept_o),
        .op_reject_o     (op_reject_o),
        .nested_susp_o   (nested_susp_o)
    );

    function automatic bit exp_admit(int st, bit bank, logic [7:0] op);
        bit common, ers;
        case (op)
            8'h03, 8'h13, 8'h3B, 8'h3C, 8'h6B, 8'h6C, 8'hBB, 8'hBC,
            8'hBD, 8'hBE, 8'hEB, 8'hEC, 8'hED, 8'hEE,
            8'h05, 8'h07, 8'hF0, 8'hB9: common = 1'b1;
            8'h01:                      common = bank;
            default:                    common = 1'b0;
        endcase
        case (op)
            8'h85, 8'h02, 8'h12, 8'h32, 8'h38, 8'h34, 8'hE2, 8'h06: ers = 1'b1;
            default: ers = 1'b0;
        endcase
        if (st == 0)      return 1'b1;
        else if (st == 1) return common | ers;
        else              return common;
    endfunction

    function automatic int next_state(int st, bit srst, bit es, bit ps, bit rs);
        if (srst) return 0;
        case (st)
            0: return es ? 1 : (ps ? 2 : 0);
            1: return rs ? 0 : (ps ? 3 : 1);
            2: return rs ? 0 : 2;
            default: return rs ? 1 : 3;
        endcase
    endfunction

    function automatic logic [7:0] pick_op(int k);
        case (k)
            0: return 8'h03;  1: return 8'h13;  2: return 8'h3B;  3: return 8'hEC;
            4: return 8'h6B;  5: return 8'hBD;  6: return 8'h05;  7: return 8'h07;
            8: return 8'hF0;  9: return 8'hB9; 10: return 8'h01; 11: return 8'h01;
            12: return 8'h85; 13: return 8'h02; 14: return 8'h12; 15: return 8'h32;
            16: return 8'h38; 17: return 8'h34; 18: return 8'hE2; 19: return 8'h06;
            20: return 8'hB9; 21: return 8'hC7; 22: return 8'h20; 23: return 8'h9F;
            default: return 8'($urandom);
        endcase
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(bit v, logic [7:0] op, bit es, bit ps, bit rs, string tag);
        bit acc;
        int nst;
        @(negedge clk);
        op_valid_i = v; opcode_i = op;
        erase_susp_evt_i = es; prog_susp_evt_i = ps; resume_evt_i = rs;
        acc = v && exp_admit(m_st, m_bank, op);
        nst = next_state(m_st, acc && op == 8'hF0, es, ps, rs);
        @(posedge clk); #1;
        chk({op_accept_o, op_reject_o} == (v ? (acc ? 2'b10 : 2'b01) : 2'b00),
            tag, "verdict", {op_accept_o, op_reject_o},
            v ? (acc ? 2 : 1) : 0);
        chk(nested_susp_o == (nst == 3), tag, "nested", nested_susp_o, nst == 3);
        if (acc) m_bank = (op == 8'hB9);
        if (acc && op == 8'hF0) m_bank = 1'b0;
        m_st = nst;
        op_valid_i = 1'b0; erase_susp_evt_i = 1'b0;
        prog_susp_evt_i = 1'b0; resume_evt_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(!op_accept_o && !op_reject_o, "R1", "verdict in reset", {op_accept_o, op_reject_o}, 0);
        chk(!nested_susp_o, "R1", "nested in reset", nested_susp_o, 0);
        @(negedge clk); rst_n = 1'b1;
        step(1'b0, 8'h00, 0, 0, 0, "R1");
        step(1'b1, 8'h01, 0, 0, 0, "R1");          // idle, no bank needed
        // R2: idle passes everything
        step(1'b1, 8'h02, 0, 0, 0, "R2");
        step(1'b1, 8'h55, 0, 0, 0, "R2");
        step(1'b1, 8'hC7, 0, 0, 0, "R2");
        // R3 / R6: erase suspend, programming commands allowed
        step(1'b0, 8'h00, 1, 0, 0, "R3");
        step(1'b1, 8'h02, 0, 0, 0, "R6");
        step(1'b1, 8'hE2, 0, 0, 0, "R6");
        step(1'b1, 8'h85, 0, 1, 0, "R3");          // nested entry
        step(1'b1, 8'h02, 0, 0, 0, "R6");          // rejected in nested
        step(1'b1, 8'h06, 0, 0, 0, "R6");
        step(1'b1, 8'h03, 0, 0, 0, "R5");
        step(1'b1, 8'h07, 0, 0, 0, "R5");
        step(1'b1, 8'hC7, 0, 0, 0, "R10");
        step(1'b0, 8'h00, 1, 0, 0, "R4");          // ignored event in nested
        // R4: resume back out
        step(1'b0, 8'h00, 0, 0, 1, "R4");
        step(1'b1, 8'h12, 0, 0, 0, "R4");
        // R8 / R9: bank ordering in erase suspend
        step(1'b1, 8'h01, 0, 0, 0, "R8");
        step(1'b1, 8'hB9, 0, 0, 0, "R8");
        step(1'b1, 8'h01, 0, 0, 0, "R8");
        step(1'b1, 8'h01, 0, 0, 0, "R8");
        step(1'b1, 8'hB9, 0, 0, 0, "R9");
        step(1'b1, 8'h55, 0, 0, 0, "R9");
        step(1'b1, 8'h01, 0, 0, 0, "R9");
        step(1'b1, 8'hB9, 0, 0, 0, "R8");
        step(1'b1, 8'h03, 0, 0, 0, "R8");
        step(1'b1, 8'h01, 0, 0, 0, "R8");
        // R11: resume wins over program suspend in erase suspend
        step(1'b0, 8'h00, 0, 1, 1, "R11");
        step(1'b1, 8'h99, 0, 0, 0, "R11");
        // R7: soft reset from program suspend, also beating events
        step(1'b0, 8'h00, 0, 1, 0, "R3");
        step(1'b1, 8'h06, 0, 0, 0, "R10");
        step(1'b1, 8'hB9, 0, 0, 0, "R7");
        step(1'b1, 8'hF0, 0, 0, 0, "R7");
        step(1'b1, 8'h77, 0, 0, 0, "R7");
        step(1'b0, 8'h00, 1, 0, 0, "R7");
        step(1'b0, 8'h00, 0, 1, 0, "R7");
        step(1'b1, 8'hF0, 1, 1, 1, "R11");
        step(1'b1, 8'h02, 0, 0, 0, "R11");
        step(1'b1, 8'h00, 1, 1, 0, "R11");        // erase wins in idle
        step(1'b1, 8'h85, 0, 0, 0, "R11");
        // random phase
        for (int i = 0; i < 4000; i++) begin
            bit v  = ($urandom % 4) != 0;
            bit es = ($urandom % 16) == 0;
            bit ps = ($urandom % 14) == 0;
            bit rs = ($urandom % 20) == 0;
            step(v, pick_op(int'($urandom % 28)), es, ps, rs, "R10");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule